// File: doc/BRIEF.md
# Page-Mode Byte Memory Target

This block models, cycle by cycle, the device side of a byte-wide parallel memory with a page mode. It samples active-low chip select, write strobe and output enable, a 17-bit address and a byte of write data on every rising clock edge. It returns a byte of read data together with a drive-enable flag that stands in for the tri-state buffer on a shared data bus. A one-cycle violation pulse flags accesses that break the timing rules.

An access opens when chip select is first sampled low. At that edge the full address is latched. The address splits into a row (bits [16:3]) and a column (bits [2:0]). While chip select stays low, the host can do three things without reopening the access:
- move to another column of the same row, which costs the short page latency;
- move to another row, which costs a full random access and honours the random cycle time;
- issue write strobe pulses to store bytes.

Raising chip select closes the access and starts a precharge interval that must run out before the next access is accepted. All latencies are parameters counted in clocks. The storage is a small register array (64 bytes by default). Address bits above the array depth are not decoded.

Top module: `pagemem_target`

## Requirements
- R1: During and after synchronous reset, `dq_oe` and `viol` are 0, and the first chip-select fall after reset is accepted without a violation.
- R2: When `ce_n` is first sampled low at edge k with `we_n` high, the full address is latched. If `oe_n` is held low, `dq_oe` stays 0 through edge k+T_ACC-1 and is 1 after edge k+T_ACC, and `dq_out` then equals the byte stored at that address.
- R3: `dq_oe` is 0 after any edge that samples `oe_n` high. Once the access has completed, sampling `oe_n` low sets `dq_oe` after that same edge.
- R4: `dq_oe` is 0 after any edge that samples `we_n` low. A write-strobe fall in the middle of a read drops the drive after the edge that samples it.
- R5: A write starts when `we_n` is sampled low, either at the chip-select fall or later. It ends at the first edge that samples `we_n` or `ce_n` high. The byte stored is `dq_in` as sampled at that ending edge, whatever `dq_in` held earlier in the pulse.
- R6: A write whose strobe was sampled low on fewer than T_ACC edges, counted from its start edge up to and excluding the ending edge, stores nothing and raises `viol` for exactly one cycle after the ending edge.
- R7: With `ce_n` low and the row unchanged, a new column value sampled at edge m gives `dq_oe` = 0 through edge m+T_PAGE-1. After edge m+T_PAGE, `dq_oe` is 1 and `dq_out` holds the byte at the new column.
- R8: While `ce_n` stays low, each further write-strobe pulse stores its byte at the column presented with the strobe's falling sample, within the latched row.
- R9: With `ce_n` low, a change of address bits [16:3] sampled at edge m starts a new random access. Data is driven after edge m+max(T_ACC, T_RC-d), where d is the number of edges since the previous access started.
- R10: A chip-select fall preceded by fewer than T_PC consecutive high samples raises `viol` for one cycle and is ignored: no drive and no write until `ce_n` rises again. A fall after exactly T_PC high samples is accepted.
- R11: Only the low log2(DEPTH) address bits index the array, so addresses that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; [16:3] row, [2:0] column |
| dq_in | input | DATA_W | Data presented by the host for writes |
| dq_out | output | DATA_W | Read data, meaningful while `dq_oe` is 1 |
| dq_oe | output | 1 | Bus drive enable (1 = block drives the bus) |
| viol | output | 1 | One-cycle pulse on a timing violation |

## Verification
The assertions watch every cycle for three things: a drive with the write strobe low or output enable high; a drive before chip select has been low for longer than the access latency; and the precharge rule in both directions, meaning a premature fall always pulses `viol` and a legal fall never does. The remaining behaviour depends on stored contents and on exact latencies, so only the bench's scenarios can show it. That covers which byte a write keeps, the page and row-change delays, rejected short writes, ignored accesses and address aliasing. The bench shows these by writing the whole array, reading it back page by page and probing each boundary one cycle on either side.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  // Phase of the current chip-select window.
  typedef enum logic [1:0] {
    PH_IDLE,  // chip select high or precharging
    PH_LIVE,  // accepted access in progress
    PH_HELD   // rejected access, waiting for chip select to rise
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pm_edges.sv
`timescale 1ns/1ps
// Registers the control strobes once and reports their transitions.
module pm_edges (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic ce_fall,
  output logic ce_rise,
  output logic we_fall,
  output logic we_rise
);
  logic ce_q, we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
    end
  end

  assign ce_fall = ce_q & ~ce_n;
  assign ce_rise = ~ce_q & ce_n;
  assign we_fall = we_q & ~we_n;
  assign we_rise = ~we_q & we_n;
endmodule

// File: rtl/pm_down.sv
`timescale 1ns/1ps
// Loadable down counter that saturates at zero.
module pm_down #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic [W-1:0] cur
);
  logic [W-1:0] nxt;

  always_comb begin
    if (load)              nxt = val;
    else if (cur != '0)    nxt = cur - 1'b1;
    else                   nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end
endmodule

// File: rtl/pm_array.sv
`timescale 1ns/1ps
// Byte store, one write port and one registered read port.
module pm_array #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pagemem_target.sv
`timescale 1ns/1ps
module pagemem_target import pm_pkg::*; #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3,
  parameter int DEPTH  = 64,
  parameter int T_ACC  = 4,
  parameter int T_PAGE = 2,
  parameter int T_RC   = 6,
  parameter int T_PC   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              viol
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(imax(imax(T_ACC, T_RC), imax(T_PAGE, T_PC)) + 2);
  localparam int NT = 4;
  // timer slots
  localparam int TA = 0;  // access latency
  localparam int TR = 1;  // random cycle spacing
  localparam int TP = 2;  // precharge
  localparam int TW = 3;  // write pulse width
  localparam logic [CW-1:0] C_ACC  = CW'(T_ACC);
  localparam logic [CW-1:0] C_PAGE = CW'(T_PAGE);
  localparam logic [CW-1:0] C_RC   = CW'(T_RC);
  localparam logic [CW-1:0] C_PC1  = CW'(T_PC - 1);
  localparam logic [CW-1:0] C_WR   = CW'(T_ACC - 1);
  localparam logic [CW-1:0] C_ONE  = CW'(1);

  logic ce_fall, ce_rise, we_fall, we_rise;

  pm_edges u_edges (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .ce_fall (ce_fall),
    .ce_rise (ce_rise),
    .we_fall (we_fall),
    .we_rise (we_rise)
  );

  logic [NT-1:0] ld;
  logic [CW-1:0] lv  [NT];
  logic [CW-1:0] cur [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    pm_down #(.W(CW)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .load (ld[i]),
      .val  (lv[i]),
      .cur  (cur[i])
    );
  end

  phase_e            ph, ph_n;
  logic [ADDR_W-1:0] lat, lat_n;
  logic              wr_on, wr_on_n;
  logic              wr_en, viol_n, acc_done_n, dq_oe_n;

  always_comb begin
    ph_n    = ph;
    lat_n   = lat;
    wr_on_n = wr_on;
    wr_en   = 1'b0;
    viol_n  = 1'b0;
    ld      = '0;
    for (int i = 0; i < NT; i++) lv[i] = '0;

    if (ce_rise) begin
      // window closes: precharge begins, a pending write ends here
      ld[TP] = 1'b1;
      lv[TP] = C_PC1;
      if (ph == PH_LIVE && wr_on) begin
        if (cur[TW] == '0) wr_en  = 1'b1;
        else               viol_n = 1'b1;
      end
      wr_on_n = 1'b0;
      ph_n    = PH_IDLE;
    end else if (ce_fall) begin
      if (cur[TP] != '0) begin
        viol_n = 1'b1;
        ph_n   = PH_HELD;
      end else begin
        ph_n    = PH_LIVE;
        lat_n   = addr;
        wr_on_n = ~we_n;
        ld[TA] = 1'b1; lv[TA] = C_ACC;
        ld[TR] = 1'b1; lv[TR] = C_RC;
        ld[TW] = 1'b1; lv[TW] = C_WR;
      end
    end else if (ph == PH_LIVE) begin
      if (wr_on) begin
        if (we_rise) begin
          if (cur[TW] == '0) wr_en  = 1'b1;
          else               viol_n = 1'b1;
          wr_on_n = 1'b0;
          ld[TA]  = 1'b1;
          lv[TA]  = C_PAGE;
        end
      end else if (we_fall) begin
        wr_on_n = 1'b1;
        ld[TW]  = 1'b1;
        lv[TW]  = C_WR;
        lat_n[COL_W-1:0] = addr[COL_W-1:0];
      end else if (addr[ADDR_W-1:COL_W] != lat[ADDR_W-1:COL_W]) begin
        // new row inside the window: full access, spaced by the cycle time
        lat_n  = addr;
        ld[TR] = 1'b1;
        lv[TR] = C_RC;
        ld[TA] = 1'b1;
        lv[TA] = (cur[TR] > C_ACC + C_ONE) ? cur[TR] - C_ONE : C_ACC;
      end else if (addr[COL_W-1:0] != lat[COL_W-1:0]) begin
        lat_n[COL_W-1:0] = addr[COL_W-1:0];
        ld[TA] = 1'b1;
        lv[TA] = (cur[TA] > C_PAGE) ? cur[TA] - C_ONE : C_PAGE;
      end
    end

    acc_done_n = ld[TA] ? (lv[TA] == '0) : (cur[TA] <= C_ONE);
    dq_oe_n    = (ph_n == PH_LIVE) && !wr_on_n && !oe_n && we_n && acc_done_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      lat   <= '0;
      wr_on <= 1'b0;
      viol  <= 1'b0;
      dq_oe <= 1'b0;
    end else begin
      ph    <= ph_n;
      lat   <= lat_n;
      wr_on <= wr_on_n;
      viol  <= viol_n;
      dq_oe <= dq_oe_n;
    end
  end

  pm_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (lat[AW-1:0]),
    .wr_data (dq_in),
    .rd_idx  (lat_n[AW-1:0]),
    .rd_data (dq_out)
  );
endmodule

// File: rtl/pm_checker.sv
`timescale 1ns/1ps
module pm_checker #(
  parameter int T_ACC = 4,
  parameter int T_PC  = 3
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic viol
);
  localparam int W = $clog2(((T_ACC > T_PC) ? T_ACC : T_PC) + 2) + 1;
  localparam logic [W-1:0] SAT   = {W{1'b1}};
  localparam logic [W-1:0] L_ACC = W'(T_ACC);
  localparam logic [W-1:0] L_PC  = W'(T_PC);

  logic         ce_q;
  logic [W-1:0] hi_run, lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      hi_run <= L_PC;
      lo_run <= '0;
    end else begin
      ce_q <= ce_n;
      if (ce_n) begin
        hi_run <= !ce_q ? W'(1) : ((hi_run == SAT) ? SAT : hi_run + 1'b1);
        lo_run <= '0;
      end else begin
        lo_run <= (lo_run == SAT) ? SAT : lo_run + 1'b1;
      end
    end
  end

  // R4
  we_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dq_oe);

  // R3
  oe_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dq_oe);

  // R2
  drive_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (lo_run > L_ACC));

  // R10
  early_select_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !ce_n && (hi_run < L_PC)) |=> viol);

  // R10
  timely_select_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !ce_n && (hi_run >= L_PC)) |=> !viol);
endmodule

bind pagemem_target pm_checker #(.T_ACC(T_ACC), .T_PC(T_PC)) u_pm_chk (
  .clk   (clk),
  .rst   (rst),
  .ce_n  (ce_n),
  .we_n  (we_n),
  .oe_n  (oe_n),
  .dq_oe (dq_oe),
  .viol  (viol)
);

// File: tb/test_pagemem_target.sv
`timescale 1ns/1ps
module test_pagemem_target;
  localparam int ADDR_W = 17;
  localparam int T_ACC  = 4;
  localparam int T_PAGE = 2;
  localparam int T_RC   = 6;
  localparam int T_PC   = 3;
  localparam int DEPTH  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dq_out;
  logic dq_oe, viol;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  pagemem_target #(
    .ADDR_W(ADDR_W), .DATA_W(8), .COL_W(3), .DEPTH(DEPTH),
    .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_RC(T_RC), .T_PC(T_PC)
  ) i_pagemem_target (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] at(input int row, input int col);
    return ADDR_W'((row << 3) | col);
  endfunction

  task automatic idle_pc();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(T_PC);
  endtask

  task automatic wr_we(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    tick(1);
    we_n = 1'b0; din = d;
    tick(T_ACC);
    we_n = 1'b1;
    tick(1);
    chk("R5", "viol after strobe-ended write", viol, 0);
    model[a[5:0]] = d;
    idle_pc();
  endtask

  task automatic wr_ce(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; din = d; we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1;
    tick(T_ACC);
    ce_n = 1'b1; we_n = 1'b1;
    tick(1);
    chk("R5", "viol after select-ended write", viol, 0);
    model[a[5:0]] = d;
    tick(T_PC - 1);
  endtask

  task automatic rd_one(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(T_ACC + 1);
    chk(req, "drive on single read", dq_oe, 1);
    chk(req, "data on single read", dq_out, exp);
    idle_pc();
  endtask

  task automatic rd_page(input int row, input string req);
    addr = at(row, 0); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(T_ACC);
    chk("R2", "no drive one cycle before access time", dq_oe, 0);
    tick(1);
    chk("R2", "drive at access time", dq_oe, 1);
    chk(req, "first byte of row", dq_out, model[(row * 8) % DEPTH]);
    for (int c = 1; c < 8; c++) begin
      addr = at(row, c);
      tick(T_PAGE);
      chk("R7", "no drive before page time", dq_oe, 0);
      tick(1);
      chk("R7", "drive at page time", dq_oe, 1);
      chk(req, "page byte", dq_out, model[(row * 8 + c) % DEPTH]);
    end
    idle_pc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    logic [7:0] keep;
    tick(3);
    // R1: reset state
    chk("R1", "drive during reset", dq_oe, 0);
    chk("R1", "viol during reset", viol, 0);
    rst = 1'b0;
    tick(2);
    chk("R1", "drive after reset", dq_oe, 0);
    chk("R1", "viol after reset", viol, 0);

    // R5: fill the array, strobe-ended and select-ended writes alternating
    for (int a = 0; a < DEPTH; a++) begin
      if (a % 2 == 0) wr_we(ADDR_W'(a), 8'(a * 37 + 5));
      else            wr_ce(ADDR_W'(a), 8'(a * 37 + 5));
    end
    // R2, R7: page-mode read-back of every row
    for (int row = 0; row < DEPTH / 8; row++) rd_page(row, "R5");

    // R3: output enable gating
    addr = 17'd9; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    tick(T_ACC + 3);
    chk("R3", "no drive with oe high", dq_oe, 0);
    oe_n = 1'b0;
    tick(1);
    chk("R3", "drive once oe low", dq_oe, 1);
    chk("R3", "data once oe low", dq_out, model[9]);
    oe_n = 1'b1;
    tick(1);
    chk("R3", "drive drops with oe high", dq_oe, 0);
    idle_pc();

    // R4, R5: read turned into write by a later strobe, data taken at the end
    addr = 17'd20; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(T_ACC + 1);
    chk("R4", "read drive before strobe", dq_oe, 1);
    we_n = 1'b0; din = 8'hA5;
    tick(1);
    chk("R4", "drive drops on strobe", dq_oe, 0);
    tick(1);
    din = 8'h3C;
    tick(T_ACC - 2);
    chk("R4", "no drive while strobe low", dq_oe, 0);
    we_n = 1'b1;
    tick(1);
    chk("R5", "viol after late-strobe write", viol, 0);
    model[20] = 8'h3C;
    chk("R4", "no drive right after write", dq_oe, 0);
    tick(T_PAGE - 1);
    chk("R7", "no drive before page time after write", dq_oe, 0);
    tick(1);
    chk("R5", "end-point byte stored", dq_out, 8'h3C);
    chk("R5", "drive after write", dq_oe, 1);
    idle_pc();

    // R6: short strobe-ended write
    addr = 17'd33; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    tick(1);
    we_n = 1'b0; din = ~model[33];
    tick(T_ACC - 1);
    we_n = 1'b1;
    tick(1);
    chk("R6", "viol on short strobe", viol, 1);
    tick(1);
    chk("R6", "viol lasts one cycle", viol, 0);
    idle_pc();
    // R6: short select-ended write
    addr = 17'd34; din = ~model[34]; we_n = 1'b0; ce_n = 1'b0;
    tick(T_ACC - 1);
    ce_n = 1'b1; we_n = 1'b1;
    tick(1);
    chk("R6", "viol on short select", viol, 1);
    tick(T_PC - 1);
    rd_one(17'd33, model[33], "R6");
    rd_one(17'd34, model[34], "R6");

    // R8: page-mode writes across row 5
    addr = at(5, 0); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    tick(1);
    for (int c = 0; c < 8; c++) begin
      addr = at(5, c); we_n = 1'b0; din = 8'(8'hC3 ^ (c * 17));
      tick(T_ACC);
      we_n = 1'b1;
      tick(1);
      chk("R8", "viol on page write", viol, 0);
      model[40 + c] = 8'(8'hC3 ^ (c * 17));
    end
    idle_pc();
    rd_page(5, "R8");

    // R9: early row change honours the random cycle time
    addr = at(2, 1); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(1);
    addr = at(6, 4);
    tick(1);
    r = (T_ACC + 1 > T_RC) ? T_ACC + 1 : T_RC;
    tick(r - 2);
    chk("R9", "no drive before cycle time", dq_oe, 0);
    tick(1);
    chk("R9", "drive at cycle time", dq_oe, 1);
    chk("R9", "new row byte", dq_out, model[52]);
    // R9: late row change costs the plain access time
    addr = at(3, 7);
    tick(T_ACC);
    chk("R9", "no drive before access after late row change", dq_oe, 0);
    tick(1);
    chk("R9", "drive after late row change", dq_oe, 1);
    chk("R9", "late row change byte", dq_out, model[31]);
    idle_pc();

    // R10: premature select is flagged and ignored
    addr = 17'd12; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(T_ACC + 1);
    ce_n = 1'b1; oe_n = 1'b1;
    tick(T_PC - 1);
    keep = model[12];
    din = ~keep; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
    tick(1);
    chk("R10", "viol on early select", viol, 1);
    tick(T_ACC + 2);
    chk("R10", "no drive in ignored access", dq_oe, 0);
    chk("R10", "single viol pulse", viol, 0);
    ce_n = 1'b1; we_n = 1'b1;
    tick(1);
    chk("R10", "no write-end viol for ignored access", viol, 0);
    tick(T_PC - 1);
    // R10: exact precharge is accepted
    addr = 17'd12; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    tick(1);
    chk("R10", "no viol at exact precharge", viol, 0);
    tick(T_ACC);
    chk("R10", "drive after exact precharge", dq_oe, 1);
    chk("R10", "byte untouched by ignored write", dq_out, keep);
    idle_pc();

    // R11: address bits above the depth are not decoded
    wr_we(ADDR_W'(64 + 5), 8'h5A);
    rd_one(17'd5, 8'h5A, "R11");
    wr_ce(17'h1FFC9, 8'h96);
    rd_one(17'd9, 8'h96, "R11");
    rd_one(ADDR_W'(128 + 20), model[20], "R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule